// File: doc/BRIEF.md
# 68000 Bus Memory Glue

This block sits between a soft 68000-style CPU core and the on-chip memories of a small single-board system. The core presents a word address (byte address bits above bit 0), a 16-bit write data bus, active-low upper and lower byte strobes and a read/write line. The glue decodes each access into a 16-bit monitor ROM, a 16-bit SRAM with per-byte write lanes, or a peripheral window that is passed out through a select output. Read data comes back combinationally, and the acknowledge is asserted in the same cycle as the strobe, so the core never sees a wait state.

The core's strobes do not frame stable write data the way a discrete 68000's do. SRAM writes are therefore committed on the falling edge of the CPU clock, with the byte strobes and the write level of the read/write line as qualifiers. After reset a boot overlay steers the first four words of the address space to the first four ROM words, which hold the initial stack pointer and program counter. The overlay stays until the first access at or above the ROM base. The ROM contents are a computed pattern so the block needs no initialisation file.

Top module: `m68k_mem_glue`

## Requirements
- R1: While rst_ni is low and afterwards until the first access, the boot overlay is active, dtack_no is high whenever neither strobe is low, and periph_sel_o is low.
- R2: uds_ni low selects data bits 15:8 and lds_ni low selects bits 7:0. A write changes only the SRAM byte lanes whose strobe is low.
- R3: An SRAM write takes effect at the falling edge of clk_i, during the low phase, and only if rw_i is 0 with at least one strobe low. An access with rw_i = 1 never changes SRAM.
- R4: While the overlay is active, byte addresses 0x0000, 0x0002, 0x0004 and 0x0006 read 0x0000, 0x0800, 0x0000 and 0x8008: a stack pointer of 0x00000800 and a program counter of 0x00008008, high word first.
- R5: The overlay is cleared at the rising clock edge that ends any access with byte address 0x8000 or above. Accesses below 0x8000 leave it set. Once cleared it stays cleared until reset, and byte addresses 0x0000 to 0x0007 then map to SRAM.
- R6: Every access is single-cycle. dtack_no is low in the same cycle as any strobe, and rdata_o reflects the selected source combinationally.
- R7: Byte addresses 0x8000 to 0xBFFF are ROM with word index (address - 0x8000) >> 1. Words 0 to 3 hold the vectors of R4, and word k >= 4 holds 0x5A00 XOR k. Writes to ROM are acknowledged and change neither the ROM nor any SRAM word.
- R8: Byte addresses 0xC000 and above assert periph_sel_o while a strobe is low, return periph_rdata_i on rdata_o, and never write SRAM.
- R9: Byte addresses 0x0000 to 0x7FFF outside the overlay are SRAM, indexed by byte address bits [SRAM_AW:1]. With SRAM_AW below 14 the array aliases within that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock; SRAM writes commit on its falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset, arms the boot overlay |
| addr_i | input | 23 | Word address, byte address bits 23:1 |
| uds_ni | input | 1 | Upper byte strobe, active low (bits 15:8) |
| lds_ni | input | 1 | Lower byte strobe, active low (bits 7:0) |
| rw_i | input | 1 | 1 = read, 0 = write |
| wdata_i | input | 16 | Write data from the core |
| rdata_o | output | 16 | Read data to the core |
| dtack_no | output | 1 | Active-low acknowledge, same cycle as the strobe |
| periph_sel_o | output | 1 | Select for the peripheral window |
| periph_rdata_i | input | 16 | Read data from the peripheral window |

## Verification
The assertions assume that the core changes address, strobes and read/write only while clk_i is high, away from the falling edge. Each access therefore spans one full cycle, and the lane enables seen at the falling edge belong to a single access. They also assume that periph_rdata_i is stable during a peripheral access. The bench drives every access one time unit after a rising edge and releases it one time unit after the next rising edge, with the peripheral data fixed. Byte writes, ROM writes and peripheral writes are aimed at SRAM words that alias the same location, so a stray write shows up on a later read.

// File: rtl/m68k_glue_pkg.sv
package m68k_glue_pkg;
  typedef enum logic [1:0] {
    RGN_SRAM   = 2'd0,
    RGN_ROM    = 2'd1,
    RGN_PERIPH = 2'd2
  } region_e;

  localparam logic [31:0] BOOT_SSP = 32'h0000_0800;
  localparam logic [31:0] BOOT_PC  = 32'h0000_8008;
  localparam logic [15:0] ROM_FILL = 16'h5A00;
endpackage

// File: rtl/glue_decode.sv
module glue_decode
  import m68k_glue_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int ROM_AW   = 13,
  parameter int ROM_BASE = 32'h8000
) (
  input  logic [ADDR_W-1:1] addr_i,
  input  logic              overlay_i,
  output region_e           region_o,
  output logic [ROM_AW-1:0] rom_idx_o,
  output logic              high_o
);
  localparam logic [ADDR_W-2:0] BASE_W  = (ADDR_W-1)'(ROM_BASE >> 1);
  localparam logic [ADDR_W-2:0] WORDS_W = (ADDR_W-1)'(1 << ROM_AW);

  logic [ADDR_W-2:0] off_w;
  logic              boot_hit;

  assign off_w    = addr_i - BASE_W;
  assign boot_hit = overlay_i && (addr_i < (ADDR_W-1)'(4));
  assign high_o   = addr_i >= BASE_W;

  always_comb begin
    rom_idx_o = off_w[ROM_AW-1:0];
    if (boot_hit) begin
      region_o  = RGN_ROM;
      rom_idx_o = {{(ROM_AW-2){1'b0}}, addr_i[2:1]};
    end else if (!high_o) begin
      region_o = RGN_SRAM;
    end else if (off_w < WORDS_W) begin
      region_o = RGN_ROM;
    end else begin
      region_o = RGN_PERIPH;
    end
  end
endmodule

// File: rtl/glue_rom.sv
module glue_rom
  import m68k_glue_pkg::*;
#(
  parameter int ROM_AW = 13
) (
  input  logic [ROM_AW-1:0] idx_i,
  output logic [15:0]       data_o
);
  always_comb begin
    case (idx_i)
      ROM_AW'(0): data_o = BOOT_SSP[31:16];
      ROM_AW'(1): data_o = BOOT_SSP[15:0];
      ROM_AW'(2): data_o = BOOT_PC[31:16];
      ROM_AW'(3): data_o = BOOT_PC[15:0];
      default:    data_o = ROM_FILL ^ 16'(idx_i);
    endcase
  end
endmodule

// File: rtl/glue_sram.sv
module glue_sram #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic [AW-1:0] idx_i,
  input  logic [1:0]    be_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o
);
  localparam int WORDS = 1 << AW;

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    logic [7:0] mem [WORDS];

    // commit in the low phase: core data is only trustworthy there
    always_ff @(negedge clk_i) begin
      if (be_i[lane]) mem[idx_i] <= wdata_i[lane*8 +: 8];
    end

    assign rdata_o[lane*8 +: 8] = mem[idx_i];
  end
endmodule

// File: rtl/m68k_mem_glue.sv
module m68k_mem_glue
  import m68k_glue_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int ROM_AW   = 13,
  parameter int SRAM_AW  = 12,
  parameter int ROM_BASE = 32'h8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:1] addr_i,
  input  logic              uds_ni,
  input  logic              lds_ni,
  input  logic              rw_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              dtack_no,
  input  logic [15:0]       periph_rdata_i,
  output logic              periph_sel_o
);
  region_e             region;
  logic [ROM_AW-1:0]   rom_idx;
  logic [15:0]         rom_data;
  logic [15:0]         sram_data;
  logic [1:0]          sram_be;
  logic                access;
  logic                high;
  logic                overlay_q;
  logic                rom_hit;

  assign access  = !uds_ni || !lds_ni;
  assign rom_hit = region == RGN_ROM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              overlay_q <= 1'b1;
    else if (access && high)  overlay_q <= 1'b0;
  end

  glue_decode #(
    .ADDR_W  (ADDR_W),
    .ROM_AW  (ROM_AW),
    .ROM_BASE(ROM_BASE)
  ) u_dec (
    .addr_i   (addr_i),
    .overlay_i(overlay_q),
    .region_o (region),
    .rom_idx_o(rom_idx),
    .high_o   (high)
  );

  glue_rom #(.ROM_AW(ROM_AW)) u_rom (
    .idx_i (rom_idx),
    .data_o(rom_data)
  );

  assign sram_be = (region == RGN_SRAM && !rw_i) ? {!uds_ni, !lds_ni} : 2'b00;

  glue_sram #(.AW(SRAM_AW)) u_sram (
    .clk_i  (clk_i),
    .idx_i  (addr_i[SRAM_AW:1]),
    .be_i   (sram_be),
    .wdata_i(wdata_i),
    .rdata_o(sram_data)
  );

  always_comb begin
    case (region)
      RGN_ROM:    rdata_o = rom_data;
      RGN_PERIPH: rdata_o = periph_rdata_i;
      default:    rdata_o = sram_data;
    endcase
  end

  assign dtack_no     = !access;
  assign periph_sel_o = access && (region == RGN_PERIPH);
endmodule

// File: rtl/glue_chk.sv
module glue_chk #(
  parameter int ADDR_W   = 24,
  parameter int ROM_BASE = 32'h8000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:1] addr_i,
  input logic              uds_ni,
  input logic              lds_ni,
  input logic              rw_i,
  input logic [15:0]       rdata_o,
  input logic [15:0]       periph_rdata_i,
  input logic              periph_sel_o,
  input logic              overlay_q,
  input logic [1:0]        sram_be,
  input logic              rom_hit
);
  localparam logic [ADDR_W-2:0] BASE_W = (ADDR_W-1)'(ROM_BASE >> 1);
  logic acc;
  assign acc = !uds_ni || !lds_ni;

  a_r2_upper_lane: assert property (@(negedge clk_i) disable iff (!rst_ni)
    sram_be[1] |-> (!uds_ni && !rw_i));
  a_r2_lower_lane: assert property (@(negedge clk_i) disable iff (!rst_ni)
    sram_be[0] |-> (!lds_ni && !rw_i));
  a_r7_rom_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_hit |-> sram_be == 2'b00);
  a_r5_overlay_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && addr_i >= BASE_W) |=> !overlay_q);
  a_r5_overlay_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !overlay_q |=> !overlay_q);
  a_r4_boot_ssp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overlay_q && acc && rw_i && addr_i == (ADDR_W-1)'(1)) |-> rdata_o == 16'h0800);
  a_r8_periph_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_sel_o |-> (rdata_o == periph_rdata_i && sram_be == 2'b00));
endmodule

bind m68k_mem_glue glue_chk #(.ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE)) u_chk (.*);

// File: tb/tb_m68k_mem_glue.sv
module tb_m68k_mem_glue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:1] addr = '0;
  logic        uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
  logic [15:0] wdata = '0, rdata, periph_rdata = 16'hA5C3;
  logic        dtack_n, periph_sel;
  int          n_chk = 0, n_fail = 0;
  logic        cap_dtack, cap_sel;

  always #5 clk = ~clk;

  m68k_mem_glue dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .uds_ni(uds_n), .lds_ni(lds_n),
    .rw_i(rw), .wdata_i(wdata), .rdata_o(rdata), .dtack_no(dtack_n),
    .periph_rdata_i(periph_rdata), .periph_sel_o(periph_sel)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    uds_n = 1'b1; lds_n = 1'b1; rw = 1'b1;
  endtask

  task automatic rd(input logic [23:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    addr = a[23:1]; rw = 1'b1; uds_n = 1'b0; lds_n = 1'b0; wdata = 16'hDEAD;
    #2; d = rdata; cap_dtack = dtack_n; cap_sel = periph_sel;
    @(posedge clk); #1; idle();
  endtask

  task automatic wr(input logic [23:0] a, input logic [15:0] d, input logic un, input logic ln);
    @(posedge clk); #1;
    addr = a[23:1]; rw = 1'b0; uds_n = un; lds_n = ln; wdata = d;
    #2; cap_dtack = dtack_n;
    @(posedge clk); #1; idle();
  endtask

  function automatic logic [15:0] rom_word(int k);
    return 16'h5A00 ^ 16'(k);
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    check("R1 idle dtack", 16'(dtack_n), 16'h1);
    check("R1 idle sel", 16'(periph_sel), 16'h0);
    rd(24'h0, d); check("R4 ssp hi", d, 16'h0000);
    check("R6 dtack same cycle", 16'(cap_dtack), 16'h0);
    rd(24'h2, d); check("R4 ssp lo", d, 16'h0800);
    rd(24'h4, d); check("R4 pc hi", d, 16'h0000);
    rd(24'h6, d); check("R4 pc lo", d, 16'h8008);
  endtask

  task automatic t_preboot_sram();
    logic [15:0] d;
    wr(24'h0010, 16'h1357, 1'b0, 1'b0);
    rd(24'h0010, d); check("R9 sram word", d, 16'h1357);
    rd(24'h0002, d); check("R5 overlay kept by low access", d, 16'h0800);
  endtask

  task automatic t_rom();
    logic [15:0] d;
    rd(24'h8002, d); check("R7 rom word1", d, 16'h0800);
    wr(24'h0000, 16'hCAFE, 1'b0, 1'b0);
    rd(24'h0000, d); check("R5 low addr now sram", d, 16'hCAFE);
    rd(24'h8010, d); check("R7 rom word8", d, rom_word(8));
    rd(24'hBFFE, d); check("R7 rom last word", d, rom_word(16'h1FFF));
    check("R8 no sel for rom", 16'(cap_sel), 16'h0);
  endtask

  task automatic t_bytes();
    logic [15:0] d;
    wr(24'h0200, 16'hBEEF, 1'b0, 1'b0);
    rd(24'h0200, d); check("R2 word write", d, 16'hBEEF);
    wr(24'h0200, 16'h55AA, 1'b0, 1'b1);
    rd(24'h0200, d); check("R2 upper lane only", d, 16'h55EF);
    wr(24'h0200, 16'h1166, 1'b1, 1'b0);
    rd(24'h0200, d); check("R2 lower lane only", d, 16'h5566);
    rd(24'h0200, d); check("R3 read leaves sram", d, 16'h5566);
  endtask

  task automatic t_low_phase();
    // drive a write and watch the same word before and after the falling edge
    @(posedge clk); #1;
    addr = 24'h0200 >> 1; rw = 1'b0; uds_n = 1'b0; lds_n = 1'b0; wdata = 16'h0F0F;
    #2; check("R3 not written in high phase", rdata, 16'h5566);
    #4; check("R3 written in low phase", rdata, 16'h0F0F);
    @(posedge clk); #1; idle();
  endtask

  task automatic t_rom_write();
    logic [15:0] d;
    wr(24'h8010, 16'h1234, 1'b0, 1'b0);
    check("R7 rom write acked", 16'(cap_dtack), 16'h0);
    rd(24'h8010, d); check("R7 rom unchanged", d, rom_word(8));
    rd(24'h0010, d); check("R7 aliased sram untouched", d, 16'h1357);
  endtask

  task automatic t_periph();
    logic [15:0] d;
    rd(24'hC000, d); check("R8 periph data", d, 16'hA5C3);
    check("R8 periph sel", 16'(cap_sel), 16'h1);
    wr(24'hC010, 16'hFFFF, 1'b0, 1'b0);
    rd(24'h0010, d); check("R8 periph write skips sram", d, 16'h1357);
    check("R9 no sel for sram", 16'(cap_sel), 16'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1 check("R1 overlay idle dtack after reset", 16'(dtack_n), 16'h1);
        t_reset();
        t_preboot_sram();
        t_rom();
        t_bytes();
        t_low_phase();
        t_rom_write();
        t_periph();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule